// File: doc/BRIEF.md
# Memory-Controller Error Status Register Block

This block holds the software-visible control and status registers of an ECC memory controller. A 32-bit word port reaches nine registers selected by word index (the byte address shifted right by two): enable, delay, fault status, video configuration, fault address 0, fault address 1, diagnostic, event count 0 and event count 1. For the first chip variant, a separate four-byte window gives byte access to diagnostic check bits. One interrupt line reports memory faults.

The error-correction datapath sits elsewhere and reports each fault through a side-band strobe that carries a status word and two address words. The block stores the captured fault and raises the interrupt when the fault needs attention. Software acknowledges the fault by writing the fault-status register. A chip-variant parameter sets which enable bits are writable, forces a variant tag into the top nibble of the enable register, and decides which enable fields survive a soft reset. A power-on reset clears all state. A soft reset clears most state but keeps selected enable fields.

Reads return data one cycle after the access, together with a valid strobe. An ignored access still returns a zero response.

Top module: `memctl_csr_block`

## Requirements
- R1: Word index 0..8 selects enable, delay, fault status, video config, fault address 0, fault address 1, diagnostic, event 0 and event 1. The index is byte address bits [ADDR_W-1:2]. A read sets rd_valid one cycle later and returns the value the register held before that edge. Indices 9 and above read as zero and ignore writes.
- R2: The variant tag sits in enable bits 31:28. Variant 0 has tag 0, variant 1 has tag 1 and variant 2 has tag 2. For variant 0, an enable write stores data & 0x00000103. For variants 1 and 2, it stores tag | (data & 0x00000BFF).
- R3: A delay write stores data & 0x7FFFFFFF, so bit 31 always reads as zero.
- R4: Any bus write to fault status stores the written word and clears irq on the next edge, unless the rule in R7 applies.
- R5: When flt_valid is high, fault status, fault address 0 and fault address 1 load from flt_status, flt_addr0 and flt_addr1. Bus writes to both fault-address registers are ignored.
- R6: A capture sets irq when flt_status bit 3 (uncorrectable) is set, or when bit 0 (correctable) is set while enable bit 1 is set. Any other capture leaves irq unchanged.
- R7: If a capture and a bus write to fault status fall in the same cycle, the captured status is stored. irq is then set if the capture meets the rule in R6, and cleared otherwise.
- R8: A soft reset keeps only enable bit 8 for variant 0. For other variants it keeps enable bits 31:24, 11 and 9:2. It sets delay to 0x20 and fault address 0 to 0x07C00000, clears every other register and irq, and leaves the diagnostic window untouched.
- R9: After power-on reset, enable holds only the variant tag, delay holds 0x20, fault address 0 holds 0x07C00000, all other registers and window bytes are zero, and irq is low.
- R10: The register window accepts only word accesses (bus_size 2). A byte access (0) or halfword access (1) does not write, and a read of either size returns zero.
- R11: For variant 0 only, the window (bus_diag=1) accepts byte accesses (bus_size 0). A write stores wdata[7:0] at address mod 4. A read returns that byte in rd_data[7:0]. Any other size, or any access on another variant, is ignored and reads as zero.
- R12: Video config, diagnostic, event 0 and event 1 each store a full 32-bit word at their own index, independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous partial reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_diag | input | 1 | 1 = diagnostic byte window, 0 = register window |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| flt_valid | input | 1 | Fault capture strobe |
| flt_status | input | 32 | Captured fault status |
| flt_addr0 | input | 32 | Captured fault address word 0 |
| flt_addr1 | input | 32 | Captured fault address word 1 |
| irq | output | 1 | Fault interrupt |

## Verification
The side-band fault capture and a software write to fault status can land on the same clock edge. The register then has two sources, and the interrupt receives a set request and a clear request together. The bench provokes this case by pulsing flt_valid in the same cycle as a word write to index 2. It does so once with a capture that does not qualify, so the interrupt must drop, and once with an uncorrectable capture, so the interrupt must rise. In both cases it reads the register back and expects the captured word rather than the bus data.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_REGS = 9;

  localparam int IX_ENABLE = 0;
  localparam int IX_DELAY  = 1;
  localparam int IX_FSTAT  = 2;
  localparam int IX_VIDEO  = 3;
  localparam int IX_FADR0  = 4;
  localparam int IX_FADR1  = 5;
  localparam int IX_DIAGR  = 6;
  localparam int IX_EVT0   = 7;
  localparam int IX_EVT1   = 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [WORD_W-1:0] DELAY_WMASK = 32'h7FFF_FFFF;
  localparam logic [WORD_W-1:0] DELAY_RST   = 32'h0000_0020;
  localparam logic [WORD_W-1:0] FADR0_RST   = 32'h07C0_0000;

  // Variant tag placed in the top nibble of the enable register.
  function automatic logic [WORD_W-1:0] variant_tag(input int unsigned v);
    return {v[3:0], {(WORD_W-4){1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] enable_wmask(input int unsigned v);
    return (v == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
  endfunction

  function automatic logic [WORD_W-1:0] enable_store(input int unsigned v,
                                                     input logic [WORD_W-1:0] d);
    return (v == 0) ? (d & enable_wmask(v)) : (variant_tag(v) | (d & enable_wmask(v)));
  endfunction

  // Fields that survive a soft reset.
  function automatic logic [WORD_W-1:0] enable_keep(input int unsigned v);
    return (v == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
  endfunction

  // Bit 0 correctable (gated by enable bit 1), bit 3 uncorrectable.
  function automatic logic irq_cause(input logic [WORD_W-1:0] en,
                                     input logic [WORD_W-1:0] st);
    return (st[0] & en[1]) | st[3];
  endfunction
endpackage

// File: rtl/csr_access_decode.sv
module csr_access_decode
  import memctl_csr_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_diag,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_REGS-1:0] reg_wr,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              main_rd,
  output logic              diag_wr,
  output logic              diag_rd,
  output logic [1:0]        diag_byte
);
  logic word_ok;
  logic byte_ok;
  logic mapped;

  assign reg_idx   = bus_addr[ADDR_W-1:2];
  assign word_ok   = bus_valid && !bus_diag && (bus_size == SZ_WORD);
  assign byte_ok   = bus_valid &&  bus_diag && (bus_size == SZ_BYTE);
  assign mapped    = (reg_idx < IDX_W'(NUM_REGS));
  assign main_rd   = word_ok && !bus_write && mapped;
  assign diag_wr   = byte_ok &&  bus_write;
  assign diag_rd   = byte_ok && !bus_write;
  assign diag_byte = bus_addr[1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wdec
    assign reg_wr[g] = word_ok && bus_write && (reg_idx == IDX_W'(g));
  end
endmodule

// File: rtl/csr_reg_file.sv
module csr_reg_file
  import memctl_csr_pkg::*;
#(
  parameter int unsigned VARIANT = 0
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  soft_rst,
  input  logic [NUM_REGS-1:0]   reg_wr,
  input  logic [WORD_W-1:0]     wdata,
  input  logic                  flt_valid,
  input  logic [WORD_W-1:0]     flt_status,
  input  logic [WORD_W-1:0]     flt_addr0,
  input  logic [WORD_W-1:0]     flt_addr1,
  output logic [NUM_REGS-1:0][WORD_W-1:0] reg_q,
  output logic                  irq
);
  localparam int N_PLAIN = 4;
  localparam int PLAIN_IDX [N_PLAIN] = '{IX_VIDEO, IX_DIAGR, IX_EVT0, IX_EVT1};

  logic [WORD_W-1:0] en_q, dly_q, fstat_q, fadr0_q, fadr1_q;
  logic [WORD_W-1:0] plain_q [N_PLAIN];
  logic irq_q;

  // Named events for the checks below.
  logic stat_wr, irq_set, irq_clr;
  assign stat_wr = reg_wr[IX_FSTAT];
  assign irq_set = flt_valid && irq_cause(en_q, flt_status);
  assign irq_clr = stat_wr && !irq_set;

  logic unused_fadr_wr;
  assign unused_fadr_wr = ^{reg_wr[IX_FADR0], reg_wr[IX_FADR1]};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                en_q <= variant_tag(VARIANT);
    else if (soft_rst)         en_q <= en_q & enable_keep(VARIANT);
    else if (reg_wr[IX_ENABLE]) en_q <= enable_store(VARIANT, wdata);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                dly_q <= DELAY_RST;
    else if (soft_rst)         dly_q <= DELAY_RST;
    else if (reg_wr[IX_DELAY]) dly_q <= wdata & DELAY_WMASK;
  end

  // Capture has priority over the bus write.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         fstat_q <= '0;
    else if (soft_rst)  fstat_q <= '0;
    else if (flt_valid) fstat_q <= flt_status;
    else if (stat_wr)   fstat_q <= wdata;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fadr0_q <= FADR0_RST;
      fadr1_q <= '0;
    end else if (soft_rst) begin
      fadr0_q <= FADR0_RST;
      fadr1_q <= '0;
    end else if (flt_valid) begin
      fadr0_q <= flt_addr0;
      fadr1_q <= flt_addr1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        irq_q <= 1'b0;
    else if (soft_rst) irq_q <= 1'b0;
    else if (irq_set)  irq_q <= 1'b1;
    else if (irq_clr)  irq_q <= 1'b0;
  end

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                     plain_q[g] <= '0;
      else if (soft_rst)              plain_q[g] <= '0;
      else if (reg_wr[PLAIN_IDX[g]])  plain_q[g] <= wdata;
    end
    assign reg_q[PLAIN_IDX[g]] = plain_q[g];
  end

  assign reg_q[IX_ENABLE] = en_q;
  assign reg_q[IX_DELAY]  = dly_q;
  assign reg_q[IX_FSTAT]  = fstat_q;
  assign reg_q[IX_FADR0]  = fadr0_q;
  assign reg_q[IX_FADR1]  = fadr1_q;
  assign irq = irq_q;

  assert_delay_msb_R3: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |-> !dly_q[WORD_W-1]);
  assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!por_n)
    (stat_wr && !flt_valid && !soft_rst) |=> !irq);
  assert_addr_ro_R5: assert property (@(posedge clk) disable iff (!por_n)
    (!flt_valid && !soft_rst) |=> ($stable(fadr0_q) && $stable(fadr1_q)));
  assert_ue_raise_R6: assert property (@(posedge clk) disable iff (!por_n)
    (flt_valid && flt_status[3] && !soft_rst) |=> irq);
  assert_capture_wins_R7: assert property (@(posedge clk) disable iff (!por_n)
    (flt_valid && stat_wr && !soft_rst) |=> (fstat_q == $past(flt_status)));
  assert_soft_rst_R8: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (!irq && fstat_q == '0 && dly_q == DELAY_RST));

  if (VARIANT != 0) begin : g_tag_chk
    assert_variant_tag_R2: assert property (@(posedge clk) disable iff (!por_n)
      1'b1 |-> (en_q[WORD_W-1:WORD_W-4] == VARIANT[3:0]));
  end
endmodule

// File: rtl/csr_diag_window.sv
module csr_diag_window
  import memctl_csr_pkg::*;
#(
  parameter int unsigned VARIANT    = 0,
  parameter int          DIAG_BYTES = 4,
  localparam int         SEL_W      = $clog2(DIAG_BYTES)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             diag_wr,
  input  logic [SEL_W-1:0] diag_byte,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);
  if (VARIANT == 0) begin : g_window
    logic [DIAG_BYTES-1:0][7:0] bytes_q;

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       bytes_q <= '0;
      else if (diag_wr) bytes_q[diag_byte] <= wbyte;
    end

    assign rbyte = bytes_q[diag_byte];

    assert_diag_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
      !diag_wr |=> $stable(bytes_q));
  end else begin : g_absent
    logic unused_diag_in;
    assign unused_diag_in = ^{clk, por_n, diag_wr, diag_byte, wbyte};
    assign rbyte = 8'h00;
  end
endmodule

// File: rtl/memctl_csr_block.sv
module memctl_csr_block
  import memctl_csr_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int          ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_diag,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              flt_valid,
  input  logic [31:0]       flt_status,
  input  logic [31:0]       flt_addr0,
  input  logic [31:0]       flt_addr1,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [NUM_REGS-1:0] reg_wr;
  logic [IDX_W-1:0]    reg_idx;
  logic main_rd, diag_wr, diag_rd;
  logic [1:0] diag_byte;
  logic [NUM_REGS-1:0][WORD_W-1:0] reg_q;
  logic [7:0] diag_rbyte;
  logic [WORD_W-1:0] main_word, rd_next;

  csr_access_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_diag(bus_diag),
    .bus_size(bus_size), .bus_addr(bus_addr),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .main_rd(main_rd),
    .diag_wr(diag_wr), .diag_rd(diag_rd), .diag_byte(diag_byte)
  );

  csr_reg_file #(.VARIANT(VARIANT)) u_regs (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
    .wdata(bus_wdata), .flt_valid(flt_valid), .flt_status(flt_status),
    .flt_addr0(flt_addr0), .flt_addr1(flt_addr1), .reg_q(reg_q), .irq(irq)
  );

  csr_diag_window #(.VARIANT(VARIANT), .DIAG_BYTES(4)) u_diag (
    .clk(clk), .por_n(por_n), .diag_wr(diag_wr), .diag_byte(diag_byte),
    .wbyte(bus_wdata[7:0]), .rbyte(diag_rbyte)
  );

  always_comb begin
    main_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (reg_idx == IDX_W'(i)) main_word = reg_q[i];
  end

  always_comb begin
    if (main_rd)      rd_next = main_word;
    else if (diag_rd) rd_next = {24'h0, diag_rbyte};
    else              rd_next = '0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_valid && !bus_write;
      rd_data  <= rd_next;
    end
  end

  assert_rd_resp_R1: assert property (@(posedge clk) disable iff (!por_n)
    (bus_valid && !bus_write) |=> rd_valid);
  assert_onehot_wr_R1: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |-> $onehot0(reg_wr));
  assert_size_filter_R10: assert property (@(posedge clk) disable iff (!por_n)
    (bus_valid && !bus_diag && bus_size != SZ_WORD) |-> (reg_wr == '0));
endmodule

// File: tb/test_memctl_csr_block.sv
`timescale 1ns/1ps
module test_memctl_csr_block;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por_n = 1'b0, soft_rst = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_diag = 1'b0;
  logic [1:0] bus_size = 2'd0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic flt_valid = 1'b0;
  logic [31:0] flt_status = '0, flt_addr0 = '0, flt_addr1 = '0;
  logic rd_valid0, rd_valid1, irq0, irq1;
  logic [31:0] rd_data0, rd_data1;

  memctl_csr_block #(.VARIANT(0), .ADDR_W(6)) i_memctl_csr_block (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_diag(bus_diag), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid0),
    .rd_data(rd_data0), .flt_valid(flt_valid), .flt_status(flt_status),
    .flt_addr0(flt_addr0), .flt_addr1(flt_addr1), .irq(irq0));

  memctl_csr_block #(.VARIANT(1), .ADDR_W(6)) i_memctl_csr_block_v1 (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_diag(bus_diag), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid1),
    .rd_data(rd_data1), .flt_valid(flt_valid), .flt_status(flt_status),
    .flt_addr0(flt_addr0), .flt_addr1(flt_addr1), .irq(irq1));

  int checks = 0, failures = 0;
  logic [31:0] m_reg [2][9];
  logic [7:0]  m_diag [4];
  logic        m_irq [2];
  logic [31:0] q_exp0 [$], q_exp1 [$];
  string       q_tag [$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_por();
    for (int v = 0; v < 2; v++) begin
      for (int i = 0; i < 9; i++) m_reg[v][i] = 32'h0;
      m_reg[v][0] = (v == 0) ? 32'h0 : 32'h1000_0000;
      m_reg[v][1] = 32'h20;
      m_reg[v][4] = 32'h07C0_0000;
      m_irq[v] = 1'b0;
    end
    for (int b = 0; b < 4; b++) m_diag[b] = 8'h0;
  endfunction

  function automatic logic [31:0] model_read(int v, logic diag, logic [1:0] sz, logic [5:0] a);
    if (diag) return (v == 0 && sz == 2'd0) ? {24'h0, m_diag[a[1:0]]} : 32'h0;
    if (sz != 2'd2 || a[5:2] > 4'd8) return 32'h0;
    return m_reg[v][a[5:2]];
  endfunction

  function automatic void model_write(int v, logic diag, logic [1:0] sz, logic [5:0] a, logic [31:0] d);
    if (diag) begin
      if (v == 0 && sz == 2'd0) m_diag[a[1:0]] = d[7:0];
      return;
    end
    if (sz != 2'd2) return;
    case (a[5:2])
      4'd0: m_reg[v][0] = (v == 0) ? (d & 32'h103) : (32'h1000_0000 | (d & 32'hBFF));
      4'd1: m_reg[v][1] = {1'b0, d[30:0]};
      4'd2: begin m_reg[v][2] = d; m_irq[v] = 1'b0; end
      4'd3, 4'd6, 4'd7, 4'd8: m_reg[v][a[5:2]] = d;
      default: ;
    endcase
  endfunction

  task automatic access(logic wr, logic diag, logic [1:0] sz, logic [5:0] a,
                        logic [31:0] d, string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_diag = diag; bus_size = sz;
    bus_addr = a; bus_wdata = d;
    if (!wr) begin
      q_exp0.push_back(model_read(0, diag, sz, a));
      q_exp1.push_back(model_read(1, diag, sz, a));
      q_tag.push_back(tag);
    end
    @(posedge clk);
    if (wr) for (int v = 0; v < 2; v++) model_write(v, diag, sz, a, d);
    #1 bus_valid = 1'b0;
  endtask

  task automatic wr_word(int idx, logic [31:0] d, string tag);
    access(1'b1, 1'b0, 2'd2, 6'(idx * 4), d, tag);
  endtask
  task automatic rd_word(int idx, string tag);
    access(1'b0, 1'b0, 2'd2, 6'(idx * 4), 32'h0, tag);
  endtask

  task automatic fault(logic [31:0] st, logic [31:0] a0, logic [31:0] a1,
                       logic with_wr, logic [31:0] d);
    @(negedge clk);
    flt_valid = 1'b1; flt_status = st; flt_addr0 = a0; flt_addr1 = a1;
    if (with_wr) begin
      bus_valid = 1'b1; bus_write = 1'b1; bus_diag = 1'b0;
      bus_size = 2'd2; bus_addr = 6'h08; bus_wdata = d;
    end
    @(posedge clk);
    for (int v = 0; v < 2; v++) begin
      logic cause;
      cause = (st[0] & m_reg[v][0][1]) | st[3];
      m_reg[v][2] = st; m_reg[v][4] = a0; m_reg[v][5] = a1;
      if (cause) m_irq[v] = 1'b1;
      else if (with_wr) m_irq[v] = 1'b0;
    end
    #1 flt_valid = 1'b0; bus_valid = 1'b0;
  endtask

  task automatic do_soft_reset();
    @(negedge clk);
    soft_rst = 1'b1;
    @(posedge clk);
    for (int v = 0; v < 2; v++) begin
      m_reg[v][0] = m_reg[v][0] & ((v == 0) ? 32'h100 : 32'hFF00_0BFC);
      for (int i = 1; i < 9; i++) m_reg[v][i] = 32'h0;
      m_reg[v][1] = 32'h20;
      m_reg[v][4] = 32'h07C0_0000;
      m_irq[v] = 1'b0;
    end
    #1 soft_rst = 1'b0;
  endtask

  task automatic check_irq(string tag);
    @(negedge clk);
    check({tag, " v0 irq"}, {31'h0, irq0}, {31'h0, m_irq[0]});
    check({tag, " v1 irq"}, {31'h0, irq1}, {31'h0, m_irq[1]});
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rd_valid0 || rd_valid1) begin
      if (q_tag.size() == 0) begin
        checks++; failures++;
        $display("FAIL R1 unexpected response actual=%h expected=none", rd_data0);
      end else begin
        string t;
        logic [31:0] e0, e1;
        t = q_tag.pop_front(); e0 = q_exp0.pop_front(); e1 = q_exp1.pop_front();
        check({t, " v0"}, rd_data0, e0);
        check({t, " v1"}, rd_data1, e1);
        check({t, " strobes"}, {30'h0, rd_valid1, rd_valid0}, 32'h3);
      end
    end
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_por();
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1;
    check_irq("R9 power-on");
    for (int i = 0; i < 9; i++) rd_word(i, "R9 power-on value");
    rd_word(9, "R1 unmapped index 9");
    rd_word(15, "R1 unmapped index 15");
    wr_word(12, 32'hFFFF_FFFF, "R1 unmapped write");

    wr_word(0, 32'hFFFF_FFFF, "R2");
    rd_word(0, "R2 enable all-ones");
    wr_word(0, 32'h0000_5AA5, "R2");
    rd_word(0, "R2 enable pattern");
    wr_word(1, 32'hFFFF_FFFF, "R3");
    rd_word(1, "R3 delay msb");
    wr_word(1, 32'h1234_5678, "R3");
    rd_word(1, "R3 delay pattern");

    wr_word(3, 32'hCAFE_0003, "R12");
    wr_word(6, 32'hCAFE_0006, "R12");
    wr_word(7, 32'h0000_1111, "R12");
    wr_word(8, 32'h0000_2222, "R12");
    rd_word(3, "R12 video"); rd_word(6, "R12 diagnostic");
    rd_word(7, "R12 event 0"); rd_word(8, "R12 event 1");

    wr_word(4, 32'hDEAD_BEEF, "R5");
    wr_word(5, 32'hDEAD_BEEF, "R5");
    rd_word(4, "R5 addr0 read-only"); rd_word(5, "R5 addr1 read-only");

    access(1'b1, 1'b0, 2'd0, 6'h0C, 32'h5555_5555, "R10");
    access(1'b1, 1'b0, 2'd1, 6'h0C, 32'h6666_6666, "R10");
    rd_word(3, "R10 narrow write ignored");
    access(1'b0, 1'b0, 2'd0, 6'h0C, 32'h0, "R10 byte read zero");
    access(1'b0, 1'b0, 2'd1, 6'h0C, 32'h0, "R10 half read zero");

    for (int b = 0; b < 4; b++)
      access(1'b1, 1'b1, 2'd0, 6'(4 + b), 32'h0000_00A0 + 32'(b), "R11");
    access(1'b1, 1'b1, 2'd2, 6'h01, 32'h0000_00FF, "R11");
    for (int b = 0; b < 4; b++)
      access(1'b0, 1'b1, 2'd0, 6'(b), 32'h0, "R11 window byte");
    access(1'b0, 1'b1, 2'd2, 6'h02, 32'h0, "R11 word read on window");

    wr_word(0, 32'h0000_0002, "R6");
    fault(32'h0000_A501, 32'h0000_0123, 32'h4567_8000, 1'b0, 32'h0);
    check_irq("R6 correctable enabled");
    rd_word(2, "R5 status captured"); rd_word(4, "R5 addr0 captured");
    rd_word(5, "R5 addr1 captured");
    wr_word(2, 32'h0000_0000, "R4");
    check_irq("R4 status write clears");
    rd_word(2, "R4 status stored");

    wr_word(0, 32'h0000_0000, "R6");
    fault(32'h0000_0001, 32'h1, 32'h2, 1'b0, 32'h0);
    check_irq("R6 correctable disabled");
    fault(32'h0000_0008, 32'h3, 32'h4, 1'b0, 32'h0);
    check_irq("R6 uncorrectable");

    fault(32'h0000_0001, 32'h5, 32'h6, 1'b1, 32'h0000_DEAD);
    check_irq("R7 same cycle no cause");
    rd_word(2, "R7 capture beats write");
    fault(32'h0000_0009, 32'h7, 32'h8, 1'b1, 32'h0000_BEEF);
    check_irq("R7 same cycle with cause");
    rd_word(2, "R7 capture beats write again");

    wr_word(0, 32'hFFFF_FFFF, "R8");
    wr_word(7, 32'h0000_7777, "R8");
    do_soft_reset();
    check_irq("R8 soft reset");
    for (int i = 0; i < 9; i++) rd_word(i, "R8 after soft reset");
    access(1'b0, 1'b1, 2'd0, 6'h03, 32'h0, "R8 window kept");

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule